// File: doc/BRIEF.md
# Sequential Maximum Reward Scanner

The scanner picks, for an automated player, the board position that earns the largest reward. It does not evaluate all positions at once. It probes them one at a time, with one position per clock. Each probe places a one-hot position code on the select output. An external reward calculator answers in the same cycle with that position's 8-bit reward. The scanner keeps a running maximum with one comparator that is reused at every step.

The sequence is driven by a step counter. The counter is cleared while the reset-state strobe is high and advances while the decision-state strobe is high. The scan follows these steps:

- **Steps 0 to NPOS-1 (probing).** Step 0 loads the first reward with no comparison. Each later step replaces the stored maximum only when the new reward is strictly larger, so equal rewards keep the lower-numbered (rightmost) position.
- **Step NPOS (play).** The select output shows the stored winner and `played` is high for that single cycle.
- **After the play.** The block rests in a done step until it is cleared again.

The strategy never skips and never subtracts.

Top module: `max_reward_scan`

## Requirements
- R1: While `clear_st` is high at a rising edge, the step counter returns to step 0. After that edge `sel` reads 0001, and `played`, `skip` and `sub` are 0.
- R2: While `decide_st` is high, each rising edge advances the step by one. While `decide_st` is low, the step holds and the presented `reward` is not stored.
- R3: In probe step k (k = 0..3), `sel` is the one-hot code with only bit k set: 0001, 0010, 0100, 1000. Bit 0 is the rightmost position.
- R4: In step 0 the presented reward and position 0 are stored with no comparison. An all-zero reward set therefore yields winner 0001.
- R5: In steps 1 to 3 the reward and the probed position are stored only if the reward is strictly greater than the stored maximum. On a tie the lowest-numbered (rightmost) position wins.
- R6: In the fifth decision cycle (step 4), `sel` equals the one-hot winner and `played` is 1. `played` is high for exactly one cycle per scan.
- R7: `skip` and `sub` are always 0. `played` is 0 during probe steps.
- R8: After the play step the block stays in a done step until the next clear, whatever `decide_st` does. In the done step `played` is 0 and `sel` keeps showing the winner.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| clear_st | input | 1 | Reset-state strobe; synchronous clear of counter and stored maximum |
| decide_st | input | 1 | Decision-state strobe; enables stepping and storing |
| reward | input | 8 | Reward of the position currently shown on `sel` |
| sel | output | 4 | One-hot probe position, then the one-hot winning position |
| played | output | 1 | High for the one cycle in which the move is made |
| skip | output | 1 | Skip request, constant 0 in this strategy |
| sub | output | 1 | Subtract request, constant 0 in this strategy |

## Verification
The assertions check the following on every cycle:

- `skip` and `sub` stay at zero.
- Each probe step shows a single-bit select.
- `played` never lasts two cycles.
- A low decision strobe freezes both the step and the stored maximum.
- The stored maximum never falls during steps 1 to 3.
- Step 0 stores exactly the presented reward.
- The done step is never left except by a clear.

Only the bench scenarios can show which position wins for a given set of rewards. These scenarios cover ascending, descending, equal, all-zero and tied-in-the-middle sets. They also show that the winner appears in exactly the fifth decision cycle, and that a stall carrying a large reward leaves the outcome unchanged.

// File: rtl/mrs_pkg.sv
package mrs_pkg;

  localparam int unsigned MRS_NPOS_DEF = 4;
  localparam int unsigned MRS_RW_DEF   = 8;

  // Counter width able to hold probe steps, the play step and the done step.
  function automatic int unsigned step_width(input int unsigned npos);
    return $clog2(npos + 2);
  endfunction

endpackage

// File: rtl/mrs_stepper.sv
module mrs_stepper #(
  parameter int unsigned NPOS = 4,
  parameter int unsigned CW   = 3
) (
  input  logic          clk,
  input  logic          clear_st,
  input  logic          decide_st,
  output logic [CW-1:0] step_q,
  output logic          probing,
  output logic          play_step,
  output logic          done_step
);

  localparam logic [CW-1:0] PLAY_IDX = CW'(NPOS);
  localparam logic [CW-1:0] DONE_IDX = CW'(NPOS + 1);

  always_ff @(posedge clk) begin
    if (clear_st) begin
      step_q <= '0;
    end else if (decide_st && (step_q != DONE_IDX)) begin
      step_q <= step_q + 1'b1;
    end
  end

  assign probing   = (step_q < PLAY_IDX);
  assign play_step = (step_q == PLAY_IDX);
  assign done_step = (step_q == DONE_IDX);

endmodule

// File: rtl/mrs_probe_dec.sv
module mrs_probe_dec #(
  parameter int unsigned NPOS = 4,
  parameter int unsigned CW   = 3
) (
  input  logic [CW-1:0]   step_q,
  output logic [NPOS-1:0] probe_sel
);

  for (genvar i = 0; i < NPOS; i++) begin : g_dec
    assign probe_sel[i] = (step_q == CW'(i));
  end

endmodule

// File: rtl/mrs_best_reg.sv
module mrs_best_reg #(
  parameter int unsigned NPOS = 4,
  parameter int unsigned RW   = 8
) (
  input  logic            clk,
  input  logic            clear_st,
  input  logic            decide_st,
  input  logic            probing,
  input  logic            first_step,
  input  logic [RW-1:0]   reward,
  input  logic [NPOS-1:0] probe_sel,
  output logic            greater,
  output logic            store_en,
  output logic [RW-1:0]   best_q,
  output logic [NPOS-1:0] pos_q
);

  // Strict comparison: equal rewards never displace the earlier position.
  function automatic logic beats(input logic [RW-1:0] cand,
                                 input logic [RW-1:0] held);
    return cand > held;
  endfunction

  assign greater  = beats(reward, best_q);
  assign store_en = decide_st & probing & (first_step | (greater & ~first_step));

  always_ff @(posedge clk) begin
    if (clear_st) begin
      best_q <= '0;
      pos_q  <= '0;
    end else if (store_en) begin
      best_q <= reward;
      pos_q  <= probe_sel;
    end
  end

endmodule

// File: rtl/max_reward_scan.sv
module max_reward_scan #(
  parameter int unsigned NPOS = mrs_pkg::MRS_NPOS_DEF,
  parameter int unsigned RW   = mrs_pkg::MRS_RW_DEF
) (
  input  logic            clk,
  input  logic            clear_st,
  input  logic            decide_st,
  input  logic [RW-1:0]   reward,
  output logic [NPOS-1:0] sel,
  output logic            played,
  output logic            skip,
  output logic            sub
);

  localparam int unsigned CW = mrs_pkg::step_width(NPOS);

  logic [CW-1:0]   step_q;
  logic            probing;
  logic            play_step;
  logic            done_step;
  logic            first_step;
  logic [NPOS-1:0] probe_sel;
  logic            greater;
  logic            store_en;
  logic [RW-1:0]   best_q;
  logic [NPOS-1:0] pos_q;

  mrs_stepper #(.NPOS(NPOS), .CW(CW)) u_step (
    .clk       (clk),
    .clear_st  (clear_st),
    .decide_st (decide_st),
    .step_q    (step_q),
    .probing   (probing),
    .play_step (play_step),
    .done_step (done_step)
  );

  mrs_probe_dec #(.NPOS(NPOS), .CW(CW)) u_dec (
    .step_q    (step_q),
    .probe_sel (probe_sel)
  );

  assign first_step = probe_sel[0];

  mrs_best_reg #(.NPOS(NPOS), .RW(RW)) u_best (
    .clk        (clk),
    .clear_st   (clear_st),
    .decide_st  (decide_st),
    .probing    (probing),
    .first_step (first_step),
    .reward     (reward),
    .probe_sel  (probe_sel),
    .greater    (greater),
    .store_en   (store_en),
    .best_q     (best_q),
    .pos_q      (pos_q)
  );

  // Probe code while scanning; the stored winner once scanning is over.
  assign sel    = probing ? probe_sel : pos_q;
  assign played = decide_st & play_step;
  assign skip   = 1'b0;
  assign sub    = 1'b0;

endmodule

// File: rtl/mrs_checker.sv
module mrs_checker #(
  parameter int unsigned NPOS = 4,
  parameter int unsigned RW   = 8,
  parameter int unsigned CW   = 3
) (
  input logic            clk,
  input logic            clear_st,
  input logic            decide_st,
  input logic [RW-1:0]   reward,
  input logic [NPOS-1:0] sel,
  input logic            played,
  input logic            skip,
  input logic            sub,
  input logic [CW-1:0]   step_q,
  input logic            probing,
  input logic            done_step,
  input logic [RW-1:0]   best_q
);

  p_flags_zero_r7: assert property (@(posedge clk) disable iff (clear_st)
    (skip == 1'b0) && (sub == 1'b0) && !(probing && played));

  p_probe_onehot_r3: assert property (@(posedge clk) disable iff (clear_st)
    probing |-> ($countones(sel) == 1));

  p_played_single_r6: assert property (@(posedge clk) disable iff (clear_st)
    played |=> !played);

  p_played_sel_r6: assert property (@(posedge clk) disable iff (clear_st)
    played |-> ($countones(sel) == 1));

  p_stall_hold_r2: assert property (@(posedge clk) disable iff (clear_st)
    !decide_st |=> ($stable(step_q) && $stable(best_q)));

  p_step0_load_r4: assert property (@(posedge clk) disable iff (clear_st)
    (decide_st && probing && (step_q == '0)) |=> (best_q == $past(reward)));

  p_max_rises_r5: assert property (@(posedge clk) disable iff (clear_st)
    (decide_st && probing && (step_q != '0)) |=> (best_q >= $past(best_q)));

  p_done_sticky_r8: assert property (@(posedge clk) disable iff (clear_st)
    done_step |=> (done_step && !played));

endmodule

bind max_reward_scan mrs_checker #(
  .NPOS (NPOS),
  .RW   (RW),
  .CW   (CW)
) u_mrs_checker (
  .clk       (clk),
  .clear_st  (clear_st),
  .decide_st (decide_st),
  .reward    (reward),
  .sel       (sel),
  .played    (played),
  .skip      (skip),
  .sub       (sub),
  .step_q    (step_q),
  .probing   (probing),
  .done_step (done_step),
  .best_q    (best_q)
);

// File: tb/max_reward_scan_bench.sv
`timescale 1ns/1ps
module max_reward_scan_bench;

  logic       clk = 1'b0;
  logic       clear_st = 1'b0;
  logic       decide_st = 1'b0;
  logic [7:0] reward = 8'd0;
  logic [3:0] sel;
  logic       played, skip, sub;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  max_reward_scan u_max_reward_scan (
    .clk(clk), .clear_st(clear_st), .decide_st(decide_st), .reward(reward),
    .sel(sel), .played(played), .skip(skip), .sub(sub)
  );

  // {r3, r2, r1, r0, expected one-hot winner}
  localparam int NV = 8;
  localparam logic [35:0] VEC [NV] = '{
    {8'd40,  8'd30,  8'd20,  8'd10,  4'b1000},
    {8'd10,  8'd20,  8'd30,  8'd40,  4'b0001},
    {8'd5,   8'd5,   8'd5,   8'd5,   4'b0001},
    {8'd0,   8'd0,   8'd0,   8'd0,   4'b0001},
    {8'd3,   8'd9,   8'd9,   8'd7,   4'b0010},
    {8'd1,   8'd255, 8'd0,   8'd255, 4'b0001},
    {8'd200, 8'd2,   8'd2,   8'd1,   4'b1000},
    {8'd100, 8'd50,  8'd100, 8'd3,   4'b0010}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Inputs change on the falling edge; outputs are sampled 1 ns later.
  task automatic do_clear();
    @(negedge clk);
    clear_st = 1'b1; decide_st = 1'b0; reward = 8'd0;
    @(negedge clk);
    clear_st = 1'b0;
    #1;
  endtask

  task automatic probe(input int k, input logic [7:0] r);
    reward = r;
    decide_st = 1'b1;
    #1;
    check($sformatf("R3 probe sel step %0d", k), {28'd0, sel}, 32'(4'b0001 << k));
    check($sformatf("R7 played low step %0d", k), {31'd0, played}, 32'd0);
    @(negedge clk);
  endtask

  task automatic finish_play(input logic [3:0] exp, input string tag);
    decide_st = 1'b1;
    #1;
    check({"R6 winner sel ", tag}, {28'd0, sel}, {28'd0, exp});
    check({"R6 played ", tag}, {31'd0, played}, 32'd1);
    @(negedge clk);
    #1;
    check({"R6 played one cycle ", tag}, {31'd0, played}, 32'd0);
    check({"R8 done sel ", tag}, {28'd0, sel}, {28'd0, exp});
    @(negedge clk);
    reward = 8'd255;
    @(negedge clk);
    decide_st = 1'b0;
    #1;
    check({"R8 done holds ", tag}, {28'd0, sel}, {28'd0, exp});
    check({"R8 no replay ", tag}, {31'd0, played}, 32'd0);
  endtask

  initial begin
    do_clear();
    check("R1 sel after clear", {28'd0, sel}, 32'h1);
    check("R1 played after clear", {31'd0, played}, 32'd0);
    check("R7 skip", {31'd0, skip}, 32'd0);
    check("R7 sub", {31'd0, sub}, 32'd0);

    for (int v = 0; v < NV; v++) begin
      do_clear();
      for (int k = 0; k < 4; k++) probe(k, VEC[v][4 + 8*k +: 8]);
      finish_play(VEC[v][3:0], $sformatf("R5 vec %0d", v));
      check("R7 skip during run", {31'd0, skip}, 32'd0);
    end

    // Stall in step 1 carrying a large reward: R2, nothing stored, step held.
    do_clear();
    probe(0, 8'd10);
    decide_st = 1'b0; reward = 8'd255;
    @(negedge clk);
    @(negedge clk);
    #1;
    check("R2 stall holds step 1", {28'd0, sel}, 32'h2);
    check("R2 stall no play", {31'd0, played}, 32'd0);
    probe(1, 8'd1);
    probe(2, 8'd30);
    probe(3, 8'd40);
    finish_play(4'b1000, "R2 after stall");

    // Clear in the middle of a scan restarts it: R1.
    do_clear();
    probe(0, 8'd1);
    probe(1, 8'd250);
    do_clear();
    check("R1 mid-scan clear sel", {28'd0, sel}, 32'h1);
    probe(0, 8'd4);
    probe(1, 8'd3);
    probe(2, 8'd9);
    probe(3, 8'd2);
    finish_play(4'b0100, "R1 restart");

    // Fifth decision cycle timing: played low in cycles 1..4: R6.
    do_clear();
    for (int k = 0; k < 4; k++) probe(k, 8'(k));
    decide_st = 1'b1;
    #1;
    check("R6 play in fifth cycle", {31'd0, played}, 32'd1);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000 && !finished) begin
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=<100000", cycles);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    end
  end

endmodule